// File: doc/BRIEF.md
# Two-Wire Controller Register Bank

This block is the register file of a two-wire serial bus controller. It has seventeen byte-wide locations, reached through a host port that reads and writes 1, 2 or 4 bytes per access. A multi-byte access is split into consecutive byte accesses. The most significant byte of the bus word goes to the lowest offset. Each byte then follows the write policy of the register it lands on. The policies are a plain store, a store through a bit mask, and write-one-to-clear.

The bus engine, the bit-rate generator and the interrupt logic all sit outside this block. They read every register through one flat output vector. The two status registers also take per-bit set pulses from that logic. Reset restores only part of the file. The address, interrupt-mask and extended-control registers keep their contents through reset.

The block has no state machine. Its only state is the register bytes. A write commits on the rising edge after the strobe. A read is answered combinationally in the same cycle.

Top module: `twi_regbank`

## Requirements
- R1: Plain-store registers hold the written byte and return it on a byte read. These are at offsets 0x00 (master data), 0x02 (slave data), 0x04/0x05 (master address low/high), 0x06 (control), 0x0A/0x0B (slave address low/high), 0x0C (divider), 0x0D (interrupt mask) and 0x0F (extended control). A register keeps its value in every cycle with no write to it.
- R2: Offsets 0x01, 0x03 and 0x11 to 0x1F are unmapped. A read of any of them returns 0x00, and a write to them changes no register.
- R3: A write to mode control (0x07) stores the byte ANDed with 0xDF.
- R4: Status (0x08) is write-one-to-clear. Only bits in mask 0x0A clear; all other bits are unaffected by host writes.
- R5: Extended status (0x09) is write-one-to-clear. Only bits in mask 0x8F clear.
- R6: Transfer count (0x0E) stores the byte ANDed with 0x77. Direct control (0x10) stores the byte ANDed with 0x07.
- R7: A 16-bit access at offset A uses data bits [15:8] for A and bits [7:0] for A+1. Read bits [31:16] are zero.
- R8: A 32-bit access at A uses bits [31:24], [23:16], [15:8] and [7:0] for A, A+1, A+2 and A+3. Each byte follows its own register's policy.
- R9: Reset sets offsets 0x00, 0x02, 0x06, 0x07, 0x08, 0x09, 0x0C and 0x0E to 0x00, and sets 0x10 to 0x0F.
- R10: Offsets 0x04, 0x05, 0x0A, 0x0B, 0x0D and 0x0F keep their values through reset.
- R11: A set pulse on a status or extended-status bit sets that bit on the next edge. It wins over a host clear of the same bit in the same cycle.
- R12: The lanes of a multi-byte access that fall past offset 0x10 are treated as unmapped: they read zero and their write data is dropped.
- R13: The size field encodes 1, 2 or 4 bytes. Any other size value makes the access void: no register changes and read data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Single-cycle access strobe |
| host_write | input | 1 | 1 = write, 0 = read |
| host_size | input | 3 | Access width in bytes: 1, 2 or 4 |
| host_addr | input | 5 | Byte offset of the first lane |
| host_wdata | input | 32 | Write data, right-justified, big-endian lanes |
| host_rdata | output | 32 | Read data, same lane layout, combinational |
| hw_sts_set | input | 8 | Set pulses for status bits |
| hw_xsts_set | input | 8 | Set pulses for extended-status bits |
| reg_bank_o | output | 136 | All seventeen bytes; offset N at bits [N*8+7:N*8] |

## Verification
Read data depends only on the present inputs and the stored bytes. The bench therefore drives a read after a falling edge and samples it 1 ns later, in the same cycle, before any rising edge. Writes and hardware set pulses commit on the first rising edge after they are driven. The bench removes them at the next falling edge and reads the result back in that cycle. Reset values are checked once rst_n has been high across one edge. The retention check after a second reset uses bytes written before that reset.

// File: rtl/twi_regbank_pkg.sv
package twi_regbank_pkg;

    localparam int NUM_OFFS  = 17;
    localparam int BYTE_W    = 8;
    localparam int ADDR_W    = 5;
    localparam int BUS_BYTES = 4;
    localparam int OFF_W     = ADDR_W + 1;
    localparam int BANK_W    = NUM_OFFS * BYTE_W;

    localparam int OFF_STS   = 8;
    localparam int OFF_XSTS  = 9;

    typedef enum logic [1:0] {
        POL_NONE,
        POL_STORE,
        POL_MASK,
        POL_W1C
    } wpol_e;

    typedef struct packed {
        wpol_e      pol;
        logic [7:0] mask;
        logic       has_rst;
        logic [7:0] rst_val;
    } cell_cfg_t;

    function automatic cell_cfg_t cfg_of(input int off);
        cell_cfg_t c;
        c = '{pol: POL_STORE, mask: 8'hFF, has_rst: 1'b1, rst_val: 8'h00};
        case (off)
            1, 3:   c.pol = POL_NONE;
            4, 5, 10, 11, 13, 15: c.has_rst = 1'b0;
            7:      begin c.pol = POL_MASK; c.mask = 8'hDF; end
            8:      begin c.pol = POL_W1C;  c.mask = 8'h0A; end
            9:      begin c.pol = POL_W1C;  c.mask = 8'h8F; end
            14:     begin c.pol = POL_MASK; c.mask = 8'h77; end
            16:     begin c.pol = POL_MASK; c.mask = 8'h07; c.rst_val = 8'h0F; end
            default: c.pol = (off < NUM_OFFS) ? POL_STORE : POL_NONE;
        endcase
        return c;
    endfunction

    function automatic int lanes_of(input logic [2:0] size);
        case (size)
            3'd1:    return 1;
            3'd2:    return 2;
            3'd4:    return 4;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/twi_lane_map.sv
module twi_lane_map
    import twi_regbank_pkg::*;
(
    input  logic                  host_valid,
    input  logic [2:0]            host_size,
    input  logic [ADDR_W-1:0]     host_addr,
    output logic [BUS_BYTES-1:0]  lane_live,
    output logic [OFF_W-1:0]      lane_off [BUS_BYTES],
    output logic [1:0]            lane_pos [BUS_BYTES]
);

    int n_lanes;

    always_comb begin
        n_lanes = lanes_of(host_size);
        for (int k = 0; k < BUS_BYTES; k++) begin
            lane_off[k]  = OFF_W'(host_addr) + OFF_W'(k);
            lane_pos[k]  = 2'(n_lanes - 1 - k);
            lane_live[k] = host_valid && (k < n_lanes) &&
                           (int'(lane_off[k]) < NUM_OFFS);
        end
    end

endmodule

// File: rtl/twi_reg_cell.sv
module twi_reg_cell
    import twi_regbank_pkg::*;
#(
    parameter wpol_e      POL     = POL_STORE,
    parameter logic [7:0] MASK    = 8'hFF,
    parameter bit         HAS_RST = 1'b1,
    parameter logic [7:0] RST_VAL = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wbyte,
    input  logic [7:0] hw_set,
    output logic [7:0] q
);

    logic [7:0] nxt;

    always_comb begin
        unique case (POL)
            POL_STORE: nxt = we ? wbyte : q;
            POL_MASK:  nxt = we ? (wbyte & MASK) : q;
            POL_W1C:   nxt = q & ~(we ? (wbyte & MASK) : 8'h00);
            default:   nxt = q;
        endcase
        nxt = nxt | hw_set;
    end

    generate
        if (HAS_RST) begin : g_rst
            always_ff @(posedge clk) begin
                if (!rst_n) q <= RST_VAL;
                else        q <= nxt;
            end
        end else begin : g_keep
            logic unused_rst;
            assign unused_rst = rst_n;
            always_ff @(posedge clk) q <= nxt;
        end
    endgenerate

endmodule

// File: rtl/twi_read_mux.sv
module twi_read_mux
    import twi_regbank_pkg::*;
(
    input  logic                 rd_en,
    input  logic [BUS_BYTES-1:0] lane_live,
    input  logic [OFF_W-1:0]     lane_off [BUS_BYTES],
    input  logic [1:0]           lane_pos [BUS_BYTES],
    input  logic [BANK_W-1:0]    bank,
    output logic [31:0]          rdata
);

    always_comb begin
        rdata = '0;
        for (int k = 0; k < BUS_BYTES; k++) begin
            if (rd_en && lane_live[k]) begin
                rdata = rdata |
                        (32'(bank[int'(lane_off[k])*BYTE_W +: BYTE_W]) << (8 * lane_pos[k]));
            end
        end
    end

endmodule

// File: rtl/twi_regbank.sv
module twi_regbank
    import twi_regbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_valid,
    input  logic              host_write,
    input  logic [2:0]        host_size,
    input  logic [4:0]        host_addr,
    input  logic [31:0]       host_wdata,
    output logic [31:0]       host_rdata,
    input  logic [7:0]        hw_sts_set,
    input  logic [7:0]        hw_xsts_set,
    output logic [135:0]      reg_bank_o
);

    logic [BUS_BYTES-1:0] lane_live;
    logic [OFF_W-1:0]     lane_off [BUS_BYTES];
    logic [1:0]           lane_pos [BUS_BYTES];
    logic [NUM_OFFS-1:0]  wr_en;
    logic [7:0]           wr_byte [NUM_OFFS];

    twi_lane_map u_map (
        .host_valid (host_valid),
        .host_size  (host_size),
        .host_addr  (host_addr),
        .lane_live  (lane_live),
        .lane_off   (lane_off),
        .lane_pos   (lane_pos)
    );

    always_comb begin
        for (int o = 0; o < NUM_OFFS; o++) begin
            wr_en[o]   = 1'b0;
            wr_byte[o] = 8'h00;
            for (int k = 0; k < BUS_BYTES; k++) begin
                if (host_write && lane_live[k] && int'(lane_off[k]) == o) begin
                    wr_en[o]   = 1'b1;
                    wr_byte[o] = 8'(host_wdata >> (8 * lane_pos[k]));
                end
            end
        end
    end

    generate
        for (genvar o = 0; o < NUM_OFFS; o++) begin : g_off
            localparam cell_cfg_t CFG = cfg_of(o);
            if (CFG.pol == POL_NONE) begin : g_hole
                assign reg_bank_o[o*BYTE_W +: BYTE_W] = '0;
            end else begin : g_cell
                logic [7:0] set_v;
                assign set_v = (o == OFF_STS)  ? hw_sts_set  :
                               (o == OFF_XSTS) ? hw_xsts_set : 8'h00;
                twi_reg_cell #(
                    .POL     (CFG.pol),
                    .MASK    (CFG.mask),
                    .HAS_RST (CFG.has_rst),
                    .RST_VAL (CFG.rst_val)
                ) u_cell (
                    .clk    (clk),
                    .rst_n  (rst_n),
                    .we     (wr_en[o]),
                    .wbyte  (wr_byte[o]),
                    .hw_set (set_v),
                    .q      (reg_bank_o[o*BYTE_W +: BYTE_W])
                );
            end
        end
    endgenerate

    twi_read_mux u_rmux (
        .rd_en     (!host_write),
        .lane_live (lane_live),
        .lane_off  (lane_off),
        .lane_pos  (lane_pos),
        .bank      (reg_bank_o),
        .rdata     (host_rdata)
    );

endmodule

// File: rtl/twi_regbank_chk.sv
module twi_regbank_chk (
    input logic         clk,
    input logic         rst_n,
    input logic         host_valid,
    input logic         host_write,
    input logic [2:0]   host_size,
    input logic [4:0]   host_addr,
    input logic [31:0]  host_wdata,
    input logic [31:0]  host_rdata,
    input logic [7:0]   hw_sts_set,
    input logic [7:0]   hw_xsts_set,
    input logic [135:0] reg_bank_o
);

    logic [7:0] mode_b, sts_b, div_b;
    assign mode_b = reg_bank_o[7*8 +: 8];
    assign sts_b  = reg_bank_o[8*8 +: 8];
    assign div_b  = reg_bank_o[12*8 +: 8];

    AST_DIV_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(host_valid && host_write) |=> $stable(div_b)); // R1

    AST_UNMAPPED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && !host_write && host_size == 3'd1 &&
         (host_addr == 5'h01 || host_addr == 5'h03 || host_addr > 5'h10))
        |-> host_rdata == 32'h0); // R2

    AST_MODE_MASKED_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (host_valid && host_write && host_size == 3'd1 && host_addr == 5'h07)
        |=> mode_b == ($past(host_wdata[7:0]) & 8'hDF)); // R3

    AST_STS_UNCLEARABLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((sts_b & $past(sts_b) & 8'hF5) == ($past(sts_b) & 8'hF5))); // R4

    AST_HW_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (|hw_sts_set) |=> ((sts_b & $past(hw_sts_set)) == $past(hw_sts_set))); // R11

endmodule

bind twi_regbank twi_regbank_chk chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_valid  (host_valid),
    .host_write  (host_write),
    .host_size   (host_size),
    .host_addr   (host_addr),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .hw_sts_set  (hw_sts_set),
    .hw_xsts_set (hw_xsts_set),
    .reg_bank_o  (reg_bank_o)
);

// File: tb/twi_regbank_tb_top.sv
module twi_regbank_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         host_valid = 1'b0;
    logic         host_write = 1'b0;
    logic [2:0]   host_size = 3'd1;
    logic [4:0]   host_addr = '0;
    logic [31:0]  host_wdata = '0;
    logic [31:0]  host_rdata;
    logic [7:0]   hw_sts_set = '0;
    logic [7:0]   hw_xsts_set = '0;
    logic [135:0] reg_bank_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    twi_regbank dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_valid  (host_valid),
        .host_write  (host_write),
        .host_size   (host_size),
        .host_addr   (host_addr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .hw_sts_set  (hw_sts_set),
        .hw_xsts_set (hw_xsts_set),
        .reg_bank_o  (reg_bank_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [2:0] sz, input logic [31:0] d);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b1; host_size = sz;
        host_addr = a; host_wdata = d;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, input logic [2:0] sz, output logic [31:0] d);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b0; host_size = sz; host_addr = a;
        #1 d = host_rdata;
        host_valid = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [2:0] sz,
                          input logic [31:0] exp);
        logic [31:0] d;
        rd(a, sz, d);
        chk(tag, d, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_vals();
        rd_chk("R9 mdata",  5'h00, 3'd1, 32'h00);
        rd_chk("R9 sdata",  5'h02, 3'd1, 32'h00);
        rd_chk("R9 ctrl",   5'h06, 3'd1, 32'h00);
        rd_chk("R9 mode",   5'h07, 3'd1, 32'h00);
        rd_chk("R9 sts",    5'h08, 3'd1, 32'h00);
        rd_chk("R9 xsts",   5'h09, 3'd1, 32'h00);
        rd_chk("R9 div",    5'h0C, 3'd1, 32'h00);
        rd_chk("R9 xfer",   5'h0E, 3'd1, 32'h00);
        rd_chk("R9 direct", 5'h10, 3'd1, 32'h0F);
    endtask

    task automatic t_plain_store();
        logic [4:0] offs [10] = '{5'h00, 5'h02, 5'h04, 5'h05, 5'h06,
                                 5'h0A, 5'h0B, 5'h0C, 5'h0D, 5'h0F};
        for (int i = 0; i < 10; i++) wr(offs[i], 3'd1, {27'h0, offs[i]} ^ 32'hA5);
        for (int i = 0; i < 10; i++)
            rd_chk($sformatf("R1 store @%02h", offs[i]), offs[i], 3'd1,
                   {27'h0, offs[i]} ^ 32'hA5);
    endtask

    task automatic t_unmapped();
        wr(5'h01, 3'd1, 32'hEE);
        wr(5'h03, 3'd1, 32'hEE);
        wr(5'h11, 3'd1, 32'hEE);
        wr(5'h1F, 3'd1, 32'hEE);
        rd_chk("R2 read 01", 5'h01, 3'd1, 32'h0);
        rd_chk("R2 read 03", 5'h03, 3'd1, 32'h0);
        rd_chk("R2 read 11", 5'h11, 3'd1, 32'h0);
        rd_chk("R2 read 1F", 5'h1F, 3'd1, 32'h0);
        rd_chk("R2 neighbour 00", 5'h00, 3'd1, 32'hA5);
        rd_chk("R2 neighbour 02", 5'h02, 3'd1, 32'hA7);
        chk("R2 bank unmapped bytes", {16'h0, reg_bank_o[8 +: 8], reg_bank_o[24 +: 8]}, 32'h0);
    endtask

    task automatic t_masks();
        wr(5'h07, 3'd1, 32'hFF);
        rd_chk("R3 mode mask", 5'h07, 3'd1, 32'hDF);
        wr(5'h0E, 3'd1, 32'hFF);
        rd_chk("R6 xfer mask", 5'h0E, 3'd1, 32'h77);
        wr(5'h10, 3'd1, 32'hFF);
        rd_chk("R6 direct mask", 5'h10, 3'd1, 32'h07);
    endtask

    task automatic t_w1c();
        @(negedge clk);
        hw_sts_set = 8'hFF; hw_xsts_set = 8'hFF;
        @(negedge clk);
        hw_sts_set = 8'h00; hw_xsts_set = 8'h00;
        rd_chk("R11 sts set", 5'h08, 3'd1, 32'hFF);
        rd_chk("R11 xsts set", 5'h09, 3'd1, 32'hFF);
        wr(5'h08, 3'd1, 32'hFF);
        rd_chk("R4 sts clear mask", 5'h08, 3'd1, 32'hF5);
        wr(5'h09, 3'd1, 32'hFF);
        rd_chk("R5 xsts clear mask", 5'h09, 3'd1, 32'h70);
    endtask

    task automatic t_priority();
        @(negedge clk);
        hw_sts_set = 8'h0A;
        @(negedge clk);
        hw_sts_set = 8'h00;
        rd_chk("R11 sts reset to FF", 5'h08, 3'd1, 32'hFF);
        @(negedge clk);
        host_valid = 1'b1; host_write = 1'b1; host_size = 3'd1;
        host_addr = 5'h08; host_wdata = 32'h0A; hw_sts_set = 8'h02;
        @(negedge clk);
        host_valid = 1'b0; host_write = 1'b0; hw_sts_set = 8'h00;
        rd_chk("R11 set beats clear", 5'h08, 3'd1, 32'hF7);
    endtask

    task automatic t_wide16();
        wr(5'h04, 3'd2, 32'h0000A1B2);
        rd_chk("R7 lo byte at A", 5'h04, 3'd1, 32'hA1);
        rd_chk("R7 hi byte at A+1", 5'h05, 3'd1, 32'hB2);
        rd_chk("R7 16-bit read", 5'h04, 3'd2, 32'h0000A1B2);
    endtask

    task automatic t_wide32();
        wr(5'h0C, 3'd4, 32'h11223344);
        rd_chk("R8 byte A", 5'h0C, 3'd1, 32'h11);
        rd_chk("R8 byte A+3", 5'h0F, 3'd1, 32'h44);
        rd_chk("R8 32-bit read", 5'h0C, 3'd4, 32'h11223344);
        wr(5'h0C, 3'd4, 32'hFFFFFFFF);
        rd_chk("R8 per-lane policy", 5'h0C, 3'd4, 32'hFFFF77FF);
    endtask

    task automatic t_edge();
        wr(5'h0F, 3'd4, 32'hAABBCCDD);
        rd_chk("R12 lane at 0F", 5'h0F, 3'd1, 32'hAA);
        rd_chk("R12 lane at 10", 5'h10, 3'd1, 32'h03);
        rd_chk("R12 32-bit past end", 5'h0F, 3'd4, 32'hAA030000);
        rd_chk("R12 16-bit past end", 5'h10, 3'd2, 32'h00000300);
    endtask

    task automatic t_badsize();
        wr(5'h00, 3'd3, 32'h55);
        rd_chk("R13 void write", 5'h00, 3'd1, 32'hA5);
        rd_chk("R13 void read", 5'h00, 3'd3, 32'h0);
    endtask

    task automatic t_retain();
        wr(5'h0D, 3'd1, 32'hFF);
        do_reset();
        rd_chk("R10 maddr lo", 5'h04, 3'd1, 32'hA1);
        rd_chk("R10 maddr hi", 5'h05, 3'd1, 32'hB2);
        rd_chk("R10 saddr", 5'h0A, 3'd2, 32'h0000AFAE);
        rd_chk("R10 irq mask", 5'h0D, 3'd1, 32'hFF);
        rd_chk("R10 xctl", 5'h0F, 3'd1, 32'hAA);
        rd_chk("R9 mdata again", 5'h00, 3'd1, 32'h00);
        rd_chk("R9 direct again", 5'h10, 3'd1, 32'h0F);
        rd_chk("R9 sts again", 5'h08, 3'd1, 32'h00);
    endtask

    initial begin
        do_reset();
        t_reset_vals();
        t_plain_store();
        t_unmapped();
        t_masks();
        t_w1c();
        t_priority();
        t_wide16();
        t_wide32();
        t_edge();
        t_badsize();
        t_retain();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule